// File: doc/BRIEF.md
# Permutation-Search Low-Power Bus Encoder

This block codes one four-line cluster of an off-chip bus, one word per bus cycle, so that as few physical wires as possible change state. For each word it tries a fixed set of sixteen line orderings. For each ordering it forms a candidate coded word from the reordered data and from the word sent last, reordered the inverse way. It then keeps the candidate whose Hamming distance to the last transmitted word is smallest. The coded word, a four-bit index naming the ordering and the distance found are registered together, and a one-cycle done flag marks them.

The search runs on a clock faster than the bus rate. A `start_i` strobe latches the data word, and a counter-driven sequencer walks the pattern set. `LANES` candidates are evaluated in parallel in each internal cycle, so a search takes `16 / LANES` cycles. A receiver that knows the previous bus word and the pattern index can undo the coding with the inverse ordering.

Top module: `bsw_encoder`

## Requirements
- R1: While `rst` is high and after its release, `enc_o`, `pidx_o`, `dist_o` and `done_o` are zero, and the stored previous bus word is zero.
- R2: Pattern n (0..15) is the n-th permutation (p0,p1,p2,p3) of the values 0..3 in lexicographic order, so index 0 is the identity and index 9 is (1,2,3,0). Reordering word x by p gives y with y[k] = x[p_k], where bit k is bit k of the vector.
- R3: For the chosen pattern p with inverse q, `enc_o` equals reorder(data,p) XOR reorder(prev,q), where prev is the previously transmitted word. Hence reorder(reorder(prev,q) XOR `enc_o`, q) returns the data word.
- R4: `dist_o` is the popcount of `enc_o` XOR prev, and it is the minimum over all sixteen candidates.
- R5: When several patterns reach the minimum distance, the lowest index is reported in `pidx_o`.
- R6: A `start_i` accepted at a clock edge makes `done_o` high for exactly one cycle, beginning after the 16/LANES-th following edge.
- R7: A `start_i` that arrives while a search is in progress is ignored: it alters neither the result nor the number of done pulses.
- R8: The outputs and the previous bus word change only when `done_o` rises, and they hold their values between searches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal search clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search for `data_i` when idle |
| data_i | input | 4 | Cluster data word, latched on an accepted start |
| enc_o | output | 4 | Coded word to drive on the bus |
| pidx_o | output | 4 | Index of the chosen pattern |
| dist_o | output | 3 | Toggle count of the chosen coded word |
| done_o | output | 1 | One-cycle flag that the outputs are new |

## Verification
The bench targets several specific faults, each with a visible effect at the ports.

- **Ties.** The first words after reset leave every candidate at the same distance. A comparator that uses less-or-equal, or that favours the wrong lane, then reports a nonzero pattern index.
- **Ignored strobes.** A second strobe carrying different data is raised in the middle of a search. A design that re-latches its data, or restarts the search, gives a result or a latency that no longer matches the first word.
- **Chaining through the previous word.** Long random runs compare every result with a bench model that holds its own copy of the previous word. A design that updates that word at the wrong time, or reorders it the direct way rather than the inverse way, diverges within a few words.
- **Round trip.** Each coded word is also decoded in the bench and compared with the original data.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  parameter int CLW  = 4;   // lines per cluster
  parameter int NPAT = 16;  // size of the pattern set (at most CLW!)

  localparam int PW = $clog2(CLW);
  localparam int IW = $clog2(NPAT);
  localparam int DW = $clog2(CLW + 1);

  typedef logic [CLW-1:0]  word_t;
  typedef logic [PW-1:0]   sel_t;
  typedef sel_t [CLW-1:0]  perm_t;
  typedef perm_t [NPAT-1:0] ptab_t;

  function automatic int fact(input int n);
    int r;
    r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  // Lexicographic enumeration of the first NPAT orderings of 0..CLW-1.
  function automatic ptab_t build_tab();
    ptab_t           t;
    int              r, f, d, cnt, pick;
    logic [CLW-1:0]  used;
    t = '0;
    for (int n = 0; n < NPAT; n++) begin
      r    = n;
      used = '0;
      for (int pos = 0; pos < CLW; pos++) begin
        f    = fact(CLW - 1 - pos);
        d    = r / f;
        r    = r % f;
        cnt  = 0;
        pick = 0;
        for (int v = 0; v < CLW; v++) begin
          if (!used[v]) begin
            if (cnt == d) pick = v;
            cnt++;
          end
        end
        used[pick] = 1'b1;
        t[n][pos]  = sel_t'(pick);
      end
    end
    return t;
  endfunction

  localparam ptab_t PTAB = build_tab();
endpackage

// File: rtl/bsw_lane.sv
module bsw_lane
  import bsw_pkg::*;
(
  input  logic [IW-1:0] idx_i,
  input  word_t         data_i,
  input  word_t         prev_i,
  output word_t         cand_o,
  output logic [DW-1:0] dist_o
);
  perm_t p;
  word_t sw_data;
  word_t sw_prev;

  always_comb begin
    p       = PTAB[idx_i];
    sw_data = '0;
    sw_prev = '0;
    for (int k = 0; k < CLW; k++) begin
      sw_data[k]    = data_i[p[k]];
      // inverse reorder: position p[k] receives bit k
      sw_prev[p[k]] = prev_i[k];
    end
    cand_o = sw_data ^ sw_prev;
    dist_o = DW'($countones(cand_o ^ prev_i));
  end
endmodule

// File: rtl/bsw_min_sel.sv
module bsw_min_sel
  import bsw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  word_t [LANES-1:0]           cand_i,
  input  logic  [LANES-1:0][DW-1:0]   dist_i,
  input  logic  [LANES-1:0][IW-1:0]   idx_i,
  output word_t                       cand_o,
  output logic  [DW-1:0]              dist_o,
  output logic  [IW-1:0]              idx_o
);
  // Lower lane carries the lower pattern index; strict compare keeps it on ties.
  always_comb begin
    cand_o = cand_i[0];
    dist_o = dist_i[0];
    idx_o  = idx_i[0];
    for (int l = 1; l < LANES; l++) begin
      if (dist_i[l] < dist_o) begin
        cand_o = cand_i[l];
        dist_o = dist_i[l];
        idx_o  = idx_i[l];
      end
    end
  end
endmodule

// File: rtl/bsw_search_ctl.sv
module bsw_search_ctl #(
  parameter int STEPS = 4,
  localparam int SW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic          first_o,
  output logic          last_o,
  output logic [SW-1:0] step_o
);
  logic          busy_q;
  logic [SW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end
    end else if (int'(step_q) == STEPS - 1) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign step_o  = step_q;
  assign first_o = busy_q && (step_q == '0);
  assign last_o  = busy_q && (int'(step_q) == STEPS - 1);
endmodule

// File: rtl/bsw_encoder.sv
module bsw_encoder
  import bsw_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [3:0]    data_i,
  output logic [3:0]    enc_o,
  output logic [3:0]    pidx_o,
  output logic [2:0]    dist_o,
  output logic          done_o
);
  localparam int STEPS = NPAT / LANES;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic          busy, first, last;
  logic [SW-1:0] step;

  word_t         data_q, prev_q;
  word_t         best_cand;
  logic [DW-1:0] best_dist;
  logic [IW-1:0] best_idx;

  word_t [LANES-1:0]          l_cand;
  logic  [LANES-1:0][DW-1:0]  l_dist;
  logic  [LANES-1:0][IW-1:0]  l_idx;

  word_t         s_cand, m_cand;
  logic [DW-1:0] s_dist, m_dist;
  logic [IW-1:0] s_idx,  m_idx;

  bsw_search_ctl #(.STEPS(STEPS)) ctl_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy),
    .first_o (first),
    .last_o  (last),
    .step_o  (step)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign l_idx[l] = IW'(int'(step) * LANES + l);
    bsw_lane lane_i (
      .idx_i  (l_idx[l]),
      .data_i (data_q),
      .prev_i (prev_q),
      .cand_o (l_cand[l]),
      .dist_o (l_dist[l])
    );
  end

  bsw_min_sel #(.LANES(LANES)) sel_i (
    .cand_i (l_cand),
    .dist_i (l_dist),
    .idx_i  (l_idx),
    .cand_o (s_cand),
    .dist_o (s_dist),
    .idx_o  (s_idx)
  );

  // Earlier steps hold lower indices, so only a strictly smaller distance wins.
  always_comb begin
    if (first || (s_dist < best_dist)) begin
      m_cand = s_cand;
      m_dist = s_dist;
      m_idx  = s_idx;
    end else begin
      m_cand = best_cand;
      m_dist = best_dist;
      m_idx  = best_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      prev_q    <= '0;
      best_cand <= '0;
      best_dist <= '0;
      best_idx  <= '0;
      enc_o     <= '0;
      pidx_o    <= '0;
      dist_o    <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy && start_i) data_q <= data_i;
      if (busy) begin
        best_cand <= m_cand;
        best_dist <= m_dist;
        best_idx  <= m_idx;
      end
      if (last) begin
        enc_o  <= m_cand;
        pidx_o <= m_idx;
        dist_o <= m_dist;
        prev_q <= m_cand;
        done_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsw_encoder_chk.sv
module bsw_encoder_chk #(
  parameter int LANES = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic [3:0] enc_o,
  input logic [3:0] pidx_o,
  input logic [2:0] dist_o,
  input logic       done_o
);
  localparam int STEPS = 16 / LANES;
  localparam int CW    = $clog2(STEPS + 1) + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == '0) begin
      if (start_i) cnt <= CW'(1);
    end else if (int'(cnt) == STEPS) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (int'(cnt) == STEPS) |=> done_o);
  assert_no_stray_done_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (int'($past(cnt)) == STEPS));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(enc_o) && $stable(pidx_o) && $stable(dist_o)));
  assert_dist_match_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones(enc_o ^ $past(enc_o)) == int'(dist_o)));
  assert_dist_range_R4: assert property (@(posedge clk) disable iff (rst)
    int'(dist_o) <= 4);
endmodule

bind bsw_encoder bsw_encoder_chk #(.LANES(LANES)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .enc_o   (enc_o),
  .pidx_o  (pidx_o),
  .dist_o  (dist_o),
  .done_o  (done_o)
);

// File: tb/bsw_encoder_tb_top.sv
module bsw_encoder_tb_top;
  localparam int LANES = 4;
  localparam int STEPS = 16 / LANES;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [3:0] data_i = '0;
  logic [3:0] enc_o, pidx_o;
  logic [2:0] dist_o;
  logic       done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [3:0] prev_m = '0;

  always #4 clk = ~clk;

  bsw_encoder #(.LANES(LANES)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
    .enc_o(enc_o), .pidx_o(pidx_o), .dist_o(dist_o), .done_o(done_o)
  );

  int PT [16][4] = '{
    '{0,1,2,3}, '{0,1,3,2}, '{0,2,1,3}, '{0,2,3,1},
    '{0,3,1,2}, '{0,3,2,1}, '{1,0,2,3}, '{1,0,3,2},
    '{1,2,0,3}, '{1,2,3,0}, '{1,3,0,2}, '{1,3,2,0},
    '{2,0,1,3}, '{2,0,3,1}, '{2,1,0,3}, '{2,1,3,0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cand_of(int n, logic [3:0] b, logic [3:0] pv);
    int q[4];
    logic [3:0] c;
    for (int k = 0; k < 4; k++) q[PT[n][k]] = k;
    for (int k = 0; k < 4; k++) c[k] = b[PT[n][k]] ^ pv[q[k]];
    return c;
  endfunction

  function automatic logic [3:0] decode(int n, logic [3:0] e, logic [3:0] pv);
    int q[4];
    logic [3:0] t, d;
    for (int k = 0; k < 4; k++) q[PT[n][k]] = k;
    for (int k = 0; k < 4; k++) t[k] = pv[q[k]] ^ e[k];
    for (int k = 0; k < 4; k++) d[k] = t[q[k]];
    return d;
  endfunction

  task automatic run_word(input logic [3:0] d, input bit inject);
    int bi, bd, cnt, dd;
    logic [3:0] bc, c, ed;
    bd = 99; bi = 0; bc = '0;
    for (int n = 0; n < 16; n++) begin
      c  = cand_of(n, d, prev_m);
      dd = $countones(c ^ prev_m);
      if (dd < bd) begin bd = dd; bi = n; bc = c; end
    end
    start_i = 1'b1;
    data_i  = d;
    cnt = 0;
    while (1) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) start_i = 1'b0;
      if (inject && cnt == 2) begin start_i = 1'b1; data_i = ~d; end
      if (inject && cnt == 3) start_i = 1'b0;
      if (done_o || cnt > 40) break;
    end
    chk(cnt == STEPS + 1, "R6 latency", cnt, STEPS + 1);
    chk(enc_o == bc, "R3 coded word", enc_o, bc);
    chk(int'(pidx_o) == bi, "R2/R5 pattern index", pidx_o, bi);
    chk(int'(dist_o) == bd, "R4 distance", dist_o, bd);
    ed = decode(int'(pidx_o), enc_o, prev_m);
    chk(ed == d, "R3 round trip", ed, d);
    prev_m = bc;
    @(negedge clk);
    chk(!done_o, "R6 single pulse", done_o, 0);
    if (inject) begin
      for (int i = 0; i < STEPS + 2; i++) begin
        @(negedge clk);
        chk(!done_o, "R7 no stray search", done_o, 0);
        chk(enc_o == bc, "R8 hold", enc_o, bc);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(enc_o == 4'd0 && pidx_o == 4'd0, "R1 reset outputs", {enc_o, pidx_o}, 0);
    chk(!done_o && dist_o == 3'd0, "R1 reset flags", {done_o, dist_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_o && enc_o == 4'd0, "R1 after release", {done_o, enc_o}, 0);
    // R5: previous word is zero, so all patterns tie
    run_word(4'b1011, 1'b0);
    chk(pidx_o == 4'd0, "R5 tie picks index 0", pidx_o, 0);
    run_word(4'b0000, 1'b0);
    run_word(4'b1111, 1'b1);
    run_word(4'b0100, 1'b0);
    run_word(4'b0110, 1'b1);
    // random stream, some with ignored strobes mid-search (R7, R8)
    for (int i = 0; i < 300; i++) begin
      run_word(4'($urandom), ($urandom % 7) == 0);
      if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule